// File: doc/BRIEF.md
# Sequential Integer Divider

This block divides one 32-bit integer by another over many clock cycles, producing the quotient and the remainder together. A requester raises a start strobe with the two operands, a 3-bit operation code and a destination register tag. From the next cycle the unit reports itself busy while it works. While busy is high the requester holds start and stalls.

Each iteration is one restoring shift-subtract step on operand magnitudes and yields one quotient bit. Signed operations are converted to magnitudes on entry, and the signs are restored on the final step. Division by zero and signed overflow give fixed, trap-free results. When the answer is ready, the unit raises a one-cycle ready pulse. In that cycle it presents a 64-bit word carrying both quotient and remainder, together with the operation code and tag captured when the operation began.

Top module: `div_unit_seq`

## Requirements
- R1: A synchronous active-high reset drives busy_o, ready_o, result_o, op_o and tag_o to zero.
- R2: When start_i is high with a valid code while busy_o is low, busy_o goes high after that clock edge and stays high for exactly 32 cycles. ready_o rises on the edge that lowers busy_o, the 33rd edge counting the accepting edge as the first.
- R3: ready_o is high for exactly one cycle per operation and is never high together with busy_o.
- R4: The unsigned codes 3'b101 (divide) and 3'b111 (remainder) treat both operands as unsigned and return the floor quotient and the non-negative remainder.
- R5: The signed codes 3'b100 (divide) and 3'b110 (remainder) use two's complement operands. The quotient is truncated toward zero and the remainder carries the dividend's sign.
- R6: For every valid code, result_o[31:0] holds the quotient and result_o[63:32] holds the remainder.
- R7: With the ready pulse, op_o and tag_o equal the op_i and tag_i values sampled on the accepting edge, and they stay unchanged while busy_o is high.
- R8: A zero divisor gives a quotient of 32'hFFFFFFFF and a remainder equal to the original dividend, for signed and unsigned codes alike.
- R9: The signed overflow case, 32'h80000000 divided by 32'hFFFFFFFF, gives a quotient of 32'h80000000 and a remainder of 0.
- R10: A start with op_i[2] equal to 0 is ignored. busy_o and ready_o stay low and result_o keeps its previous value.
- R11: While busy_o is high, start_i, the operands, op_i and tag_i are ignored. The result, op_o and tag_o belong to the operation that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an operation |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| op_i | input | 3 | Operation code |
| tag_i | input | 5 | Destination register tag |
| busy_o | output | 1 | Calculation in progress |
| ready_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 64 | Remainder in [63:32], quotient in [31:0] |
| op_o | output | 3 | Operation code of the finished operation |
| tag_o | output | 5 | Tag of the finished operation |

## Verification
busy_o is due one edge after the accepting edge. ready_o, result_o, op_o and tag_o are due together on the 33rd edge. The bench drives inputs on falling edges and counts falling edges from the accepting edge. It requires busy_o on the first one and ready_o on exactly the 33rd. It then checks that ready_o has gone low one falling edge later. The bench releases start_i on the same falling edge where it sees ready, so that no new operation is accepted on the next edge.

// File: rtl/div_unit_pkg.sv
package div_unit_pkg;
  localparam int OP_W  = 3;
  localparam int TAG_W = 5;

  localparam logic [OP_W-1:0] OP_SDIV = 3'b100;
  localparam logic [OP_W-1:0] OP_UDIV = 3'b101;
  localparam logic [OP_W-1:0] OP_SREM = 3'b110;
  localparam logic [OP_W-1:0] OP_UREM = 3'b111;

  // every divide-family code has the top bit set
  function automatic logic op_valid(input logic [OP_W-1:0] op);
    return op[OP_W-1];
  endfunction

  // even codes in the family are the signed ones
  function automatic logic op_signed(input logic [OP_W-1:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] dvnd_mag_o,
  output logic [WIDTH-1:0] dvsr_mag_o,
  output logic             neg_quo_o,
  output logic             neg_rem_o,
  output logic             dvsr_zero_o
);
  logic is_signed, a_neg, b_neg;

  always_comb begin
    is_signed   = op_signed(op_i);
    a_neg       = is_signed & dividend_i[WIDTH-1];
    b_neg       = is_signed & divisor_i[WIDTH-1];
    dvnd_mag_o  = a_neg ? (~dividend_i + 1'b1) : dividend_i;
    dvsr_mag_o  = b_neg ? (~divisor_i + 1'b1) : divisor_i;
    neg_quo_o   = a_neg ^ b_neg;
    neg_rem_o   = a_neg;
    dvsr_zero_o = (divisor_i == '0);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvsr_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH:0] trial, diff;
  logic           fits;

  always_comb begin
    trial = {rem_i, quo_i[WIDTH-1]};
    diff  = trial - {1'b0, dvsr_i};
    fits  = ~diff[WIDTH];
    rem_o = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    quo_o = {quo_i[WIDTH-2:0], fits};
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   quo_mag_i,
  input  logic [WIDTH-1:0]   rem_mag_i,
  input  logic               neg_quo_i,
  input  logic               neg_rem_i,
  input  logic               dvsr_zero_i,
  input  logic [WIDTH-1:0]   dividend_raw_i,
  output logic [2*WIDTH-1:0] packed_o
);
  logic [WIDTH-1:0] quo, rem;

  always_comb begin
    if (dvsr_zero_i) begin
      quo = '1;
      rem = dividend_raw_i;
    end else begin
      quo = neg_quo_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
      rem = neg_rem_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    end
    packed_o = {rem, quo};
  end
endmodule

// File: rtl/div_unit_seq.sv
module div_unit_seq
  import div_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   dividend_i,
  input  logic [WIDTH-1:0]   divisor_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic               busy_o,
  output logic               ready_o,
  output logic [2*WIDTH-1:0] result_o,
  output logic [OP_W-1:0]    op_o,
  output logic [TAG_W-1:0]   tag_o
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] mag_a, mag_b;
  logic             pre_neg_q, pre_neg_r, pre_zero;

  logic [WIDTH-1:0] rem_q, quo_q, dvsr_q, raw_a_q;
  logic             neg_q_q, neg_r_q, zero_q;
  logic [CNT_W-1:0] cnt_q;

  logic [WIDTH-1:0]   rem_nx, quo_nx;
  logic [2*WIDTH-1:0] final_word;
  logic               accept;

  div_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .op_i       (op_i),
    .dvnd_mag_o (mag_a),
    .dvsr_mag_o (mag_b),
    .neg_quo_o  (pre_neg_q),
    .neg_rem_o  (pre_neg_r),
    .dvsr_zero_o(pre_zero)
  );

  div_step #(.WIDTH(WIDTH)) step_i (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dvsr_i(dvsr_q),
    .rem_o (rem_nx),
    .quo_o (quo_nx)
  );

  div_result_fix #(.WIDTH(WIDTH)) fix_i (
    .quo_mag_i     (quo_nx),
    .rem_mag_i     (rem_nx),
    .neg_quo_i     (neg_q_q),
    .neg_rem_i     (neg_r_q),
    .dvsr_zero_i   (zero_q),
    .dividend_raw_i(raw_a_q),
    .packed_o      (final_word)
  );

  assign accept = start_i & op_valid(op_i) & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      ready_o  <= 1'b0;
      result_o <= '0;
      op_o     <= '0;
      tag_o    <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      dvsr_q   <= '0;
      raw_a_q  <= '0;
      neg_q_q  <= 1'b0;
      neg_r_q  <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (accept) begin
        busy_o  <= 1'b1;
        cnt_q   <= '0;
        rem_q   <= '0;
        quo_q   <= mag_a;
        dvsr_q  <= mag_b;
        raw_a_q <= dividend_i;
        neg_q_q <= pre_neg_q;
        neg_r_q <= pre_neg_r;
        zero_q  <= pre_zero;
        op_o    <= op_i;
        tag_o   <= tag_i;
      end else if (busy_o) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) begin
          busy_o   <= 1'b0;
          ready_o  <= 1'b1;
          result_o <= final_word;
        end
      end
    end
  end
endmodule

// File: rtl/div_unit_seq_chk.sv
module div_unit_seq_chk #(
  parameter int WIDTH = 32,
  parameter int OP_W  = 3,
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [OP_W-1:0]  op_i,
  input logic             busy_o,
  input logic             ready_o,
  input logic [OP_W-1:0]  op_o,
  input logic [TAG_W-1:0] tag_o
);
  localparam int BC_W = $clog2(WIDTH) + 2;
  logic [BC_W-1:0] busy_cycles;

  always_ff @(posedge clk) begin
    if (rst)         busy_cycles <= '0;
    else if (busy_o) busy_cycles <= busy_cycles + 1'b1;
    else             busy_cycles <= '0;
  end

  // R3: never busy and ready at once
  a_r3_not_both: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && ready_o));

  // R3: ready lasts one cycle
  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R2: valid request while idle starts the unit
  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_i[OP_W-1] && !busy_o) |=> busy_o);

  // R2: ready arrives after exactly WIDTH busy cycles
  a_r2_busy_len: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (busy_cycles == BC_W'(WIDTH)));

  // R10: invalid code does not start the unit
  a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
    (start_i && !op_i[OP_W-1] && !busy_o) |=> (!busy_o && !ready_o));

  // R7 / R11: echoed code and tag held while busy
  a_r7_echo_stable: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(tag_o) && $stable(op_o)));
endmodule

bind div_unit_seq div_unit_seq_chk #(.WIDTH(WIDTH), .OP_W(3), .TAG_W(5)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .op_i   (op_i),
  .busy_o (busy_o),
  .ready_o(ready_o),
  .op_o   (op_o),
  .tag_o  (tag_o)
);

// File: tb/div_unit_seq_tb_top.sv
`timescale 1ns/1ps
module div_unit_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [31:0] dividend_i, divisor_i;
  logic [2:0]  op_i;
  logic [4:0]  tag_i;
  logic        busy_o, ready_o;
  logic [63:0] result_o;
  logic [2:0]  op_o;
  logic [4:0]  tag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  div_unit_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .op_i(op_i), .tag_i(tag_i), .busy_o(busy_o),
    .ready_o(ready_o), .result_o(result_o), .op_o(op_o), .tag_o(tag_o)
  );

  // {op, dividend, divisor, quotient, remainder}
  localparam int NV = 10;
  localparam logic [130:0] VEC [NV] = '{
    {3'b101, 32'd100,        32'd7,        32'd14,       32'd2},        // R4
    {3'b111, 32'hFFFFFFFF,   32'h00000010, 32'h0FFFFFFF, 32'h0000000F}, // R4
    {3'b100, 32'hFFFFFFF9,   32'd2,        32'hFFFFFFFD, 32'hFFFFFFFF}, // R5
    {3'b110, 32'd7,          32'hFFFFFFFE, 32'hFFFFFFFD, 32'd1},        // R5
    {3'b100, 32'hFFFFFFF8,   32'hFFFFFFFD, 32'd2,        32'hFFFFFFFE}, // R5
    {3'b101, 32'd5,          32'd0,        32'hFFFFFFFF, 32'd5},        // R8
    {3'b100, 32'hFFFFFFFB,   32'd0,        32'hFFFFFFFF, 32'hFFFFFFFB}, // R8
    {3'b100, 32'h80000000,   32'hFFFFFFFF, 32'h80000000, 32'd0},        // R9
    {3'b101, 32'h80000000,   32'hFFFFFFFF, 32'd0,        32'h80000000}, // R4
    {3'b110, 32'd3,          32'd10,       32'd0,        32'd3}         // R5/R6
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // start an operation; optionally disturb inputs mid-flight; wait for ready
  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [4:0] tag, input bit disturb, output int cyc);
    @(negedge clk);
    start_i = 1'b1; op_i = op; dividend_i = a; divisor_i = b; tag_i = tag;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check("R2 busy after accept", {63'd0, busy_o}, 64'd1);
      if (disturb && cyc == 5) begin
        dividend_i = 32'h12345678; divisor_i = 32'd3; op_i = 3'b111; tag_i = ~tag;
      end
    end while (!ready_o && cyc < 100);
    start_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [63:0] held;
    rst = 1'b1; start_i = 1'b0; op_i = '0; dividend_i = '0; divisor_i = '0; tag_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy",   {63'd0, busy_o},  64'd0);
    check("R1 ready",  {63'd0, ready_o}, 64'd0);
    check("R1 result", result_o,         64'd0);
    check("R1 op/tag", {56'd0, op_o, tag_o}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] vop;
      logic [31:0] va, vb, vq, vr;
      {vop, va, vb, vq, vr} = VEC[i];
      run_op(vop, va, vb, 5'(i + 3), 1'b0, cyc);
      check("R2 ready on 33rd edge", 64'(cyc), 64'd33);
      check("R4/R5/R8/R9 quotient in R6 low half", {32'd0, result_o[31:0]}, {32'd0, vq});
      check("R4/R5/R8/R9 remainder in R6 high half", {32'd0, result_o[63:32]}, {32'd0, vr});
      check("R7 op and tag echo", {56'd0, op_o, tag_o}, {56'd0, vop, 5'(i + 3)});
      @(negedge clk);
      check("R3 ready single pulse", {62'd0, ready_o, busy_o}, 64'd0);
    end

    // R10: invalid codes ignored
    held = result_o;
    @(negedge clk);
    start_i = 1'b1; op_i = 3'b001; dividend_i = 32'd9; divisor_i = 32'd2; tag_i = 5'd30;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0 || k == 33) check("R10 bad op no busy/ready", {62'd0, busy_o, ready_o}, 64'd0);
      if (k == 3) op_i = 3'b011;
    end
    start_i = 1'b0;
    check("R10 result unchanged", result_o, held);

    // R11: inputs changed during busy are ignored
    run_op(3'b101, 32'd1000, 32'd33, 5'd17, 1'b1, cyc);
    check("R11 ready timing", 64'(cyc), 64'd33);
    check("R11 result of accepted op", result_o, {32'd10, 32'd30});
    check("R11 op/tag of accepted op", {56'd0, op_o, tag_o}, {56'd0, 3'b101, 5'd17});

    // R1: reset mid-operation clears everything
    run_op(3'b100, 32'd50, 32'd5, 5'd9, 1'b0, cyc);
    @(negedge clk);
    start_i = 1'b1; op_i = 3'b101; dividend_i = 32'd77; divisor_i = 32'd7; tag_i = 5'd4;
    repeat (4) @(negedge clk);
    start_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-op reset busy/ready", {62'd0, busy_o, ready_o}, 64'd0);
    check("R1 mid-op reset result", result_o, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule